// File: doc/BRIEF.md
# Correlating (m,n) Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of saturating counters, `CTR_BITS` wide. A branch picks a row with a few low bits of its address. Within that row, the outcomes of the last `HIST_BITS` resolved branches pick one counter. As a result, the guess for a branch depends on the branch itself and on the branches that ran just before it.

The block has two ports. The predict port takes a fetch address and returns the direction at once, from the current table and the current history. The update port takes a resolved branch address and its real outcome. On the next clock edge, the selected counter moves one step toward that outcome and the outcome is shifted into the global history.

Each counter works as a small state machine. Its states run from 0 (strongly not-taken) up to 2^`CTR_BITS`-1 (strongly taken). With the default width these are the four states SNT=00, WNT=01, WT=10 and ST=11. The transitions are:
- a taken update moves the counter up one state (SNT→WNT→WT→ST, and ST stays ST);
- a not-taken update moves it down one state (ST→WT→WNT→SNT, and SNT stays SNT);
- with no update the counter holds.

In the logic, each write is sorted into one of three moves: INC, DEC or HOLD.

Top module: `cbp_predictor`

## Requirements
- R1: After reset, every counter is in state WNT (value 2^(CTR_BITS-1)-1, which is 01 for two-bit counters) and the global history is all zeros, so every address predicts not-taken.
- R2: The counter index is {PC[PC_LSB+ROW_BITS-1:PC_LSB], history}, with defaults PC[5:2] and a 2-bit history. No other PC bit affects a prediction or an update.
- R3: `pred_taken` is the most significant bit of the selected counter.
- R4: An update with `upd_taken`=1 increments the selected counter, and the counter saturates at 2^CTR_BITS-1.
- R5: An update with `upd_taken`=0 decrements the selected counter, and the counter saturates at 0.
- R6: After each update, the history shifts left by one and the outcome enters bit 0 (1 = taken, newest in the LSB). A history of 01 means the older branch was not taken and the most recent one was taken.
- R7: An update selects its counter with the history value from before that update's own shift.
- R8: When a prediction and an update fall in the same cycle, the prediction uses the counter values and the history from before the update.
- R9: When `upd_valid` is 0, `upd_pc` and `upd_taken` have no effect: neither the counters nor the history change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | PC_W | Address of the branch to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
Prediction and training can both happen in one cycle. When they do, the prediction must see the table and the history as they were before the training edge. The bench provokes this in two ways. In directed runs it predicts the very address it is training. In a long random run every cycle carries both a prediction and an update, often on the same row. A reference model in the bench computes the expected direction from its own state before the update, and compares it with `pred_taken` before the edge that applies the update.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

    // Kind of step a counter takes on a clock edge
    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,
        MV_INC  = 2'd1,
        MV_DEC  = 2'd2
    } ctr_move_e;

endpackage

// File: rtl/cbp_ghr.sv
// Global outcome history: shift register, newest outcome enters bit 0.
module cbp_ghr #(
    parameter int HIST_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 outcome,
    output logic [HIST_BITS-1:0] hist
);

    logic [HIST_BITS-1:0] hist_nxt;

    generate
        if (HIST_BITS > 1) begin : g_wide
            always_comb hist_nxt = {hist[HIST_BITS-2:0], outcome};
        end else begin : g_single
            always_comb hist_nxt = outcome;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= hist_nxt;
        end
    end

    AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist[0] == $past(outcome)); // R6

    generate
        if (HIST_BITS > 1) begin : g_age_chk
            AST_HIST_AGES: assert property (@(posedge clk) disable iff (!rst_n)
                shift_en |=> hist[HIST_BITS-1:1] == $past(hist[HIST_BITS-2:0])); // R6
        end
    endgenerate

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist)); // R9

endmodule

// File: rtl/cbp_index.sv
// Builds the table index from the row bits of an address and the history.
module cbp_index #(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int ROW_BITS  = 4,
    parameter int HIST_BITS = 2
) (
    input  logic [PC_W-1:0]               pc,
    input  logic [HIST_BITS-1:0]          hist,
    output logic [ROW_BITS+HIST_BITS-1:0] idx
);

    localparam logic [PC_W-1:0] ROW_MASK =
        ((PC_W'(1) << ROW_BITS) - PC_W'(1)) << PC_LSB;

    logic [ROW_BITS-1:0] row;
    logic                unused_pc_bits;

    always_comb begin
        row            = pc[PC_LSB +: ROW_BITS];
        idx            = {row, hist};
        unused_pc_bits = ^(pc & ~ROW_MASK);
    end

    initial begin
        AST_INDEX_FITS: assert (PC_LSB + ROW_BITS <= PC_W); // R2
    end

endmodule

// File: rtl/cbp_pht.sv
// Table of saturating direction counters: one read port, one write port.
module cbp_pht #(
    parameter int ROW_BITS  = 4,
    parameter int HIST_BITS = 2,
    parameter int CTR_BITS  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ROW_BITS+HIST_BITS-1:0] rd_idx,
    output logic [CTR_BITS-1:0]           rd_ctr,
    input  logic                          wr_en,
    input  logic [ROW_BITS+HIST_BITS-1:0] wr_idx,
    input  logic                          wr_taken
);
    import cbp_pkg::*;

    localparam int IDX_W = ROW_BITS + HIST_BITS;
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CTR_BITS-1:0] CTR_MAX  = '1;
    localparam logic [CTR_BITS-1:0] CTR_INIT = CTR_MAX >> 1;

    logic [CTR_BITS-1:0] tbl [DEPTH];
    logic [CTR_BITS-1:0] wr_cur;
    logic [CTR_BITS-1:0] wr_nxt;
    ctr_move_e           move;

    always_comb begin
        rd_ctr = tbl[rd_idx];
        wr_cur = tbl[wr_idx];
    end

    // Classify the step
    always_comb begin
        move = MV_HOLD;
        if (wr_en) begin
            if (wr_taken && (wr_cur != CTR_MAX)) begin
                move = MV_INC;
            end else if (!wr_taken && (wr_cur != '0)) begin
                move = MV_DEC;
            end
        end
    end

    // Next value of the written counter
    always_comb begin
        unique case (move)
            MV_INC:  wr_nxt = wr_cur + 1'b1;
            MV_DEC:  wr_nxt = wr_cur - 1'b1;
            default: wr_nxt = wr_cur;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl[i] <= CTR_INIT;
            end
        end else if (move != MV_HOLD) begin
            tbl[wr_idx] <= wr_nxt;
        end
    end

    AST_CTR_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && wr_cur != CTR_MAX)
        |=> tbl[$past(wr_idx)] == $past(wr_cur) + 1'b1); // R4

    AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && wr_cur == CTR_MAX)
        |=> tbl[$past(wr_idx)] == CTR_MAX); // R4

    AST_CTR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && wr_cur != '0)
        |=> tbl[$past(wr_idx)] == $past(wr_cur) - 1'b1); // R5

    AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && wr_cur == '0)
        |=> tbl[$past(wr_idx)] == '0); // R5

    AST_CTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_ctr) || !$stable(rd_idx)); // R9

endmodule

// File: rtl/cbp_predictor.sv
// (m,n) correlating branch direction predictor, top level.
module cbp_predictor #(
    parameter int PC_W      = 32,
    parameter int PC_LSB    = 2,
    parameter int ROW_BITS  = 4,
    parameter int HIST_BITS = 2,
    parameter int CTR_BITS  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);

    localparam int IDX_W = ROW_BITS + HIST_BITS;

    logic [HIST_BITS-1:0] hist;
    logic [IDX_W-1:0]     pred_idx;
    logic [IDX_W-1:0]     upd_idx;
    logic [CTR_BITS-1:0]  pred_ctr;

    cbp_ghr #(
        .HIST_BITS (HIST_BITS)
    ) u_ghr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid),
        .outcome  (upd_taken),
        .hist     (hist)
    );

    cbp_index #(
        .PC_W      (PC_W),
        .PC_LSB    (PC_LSB),
        .ROW_BITS  (ROW_BITS),
        .HIST_BITS (HIST_BITS)
    ) u_pred_index (
        .pc   (pred_pc),
        .hist (hist),
        .idx  (pred_idx)
    );

    cbp_index #(
        .PC_W      (PC_W),
        .PC_LSB    (PC_LSB),
        .ROW_BITS  (ROW_BITS),
        .HIST_BITS (HIST_BITS)
    ) u_upd_index (
        .pc   (upd_pc),
        .hist (hist),
        .idx  (upd_idx)
    );

    cbp_pht #(
        .ROW_BITS  (ROW_BITS),
        .HIST_BITS (HIST_BITS),
        .CTR_BITS  (CTR_BITS)
    ) u_pht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_idx),
        .rd_ctr   (pred_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (upd_idx),
        .wr_taken (upd_taken)
    );

    always_comb pred_taken = pred_ctr[CTR_BITS-1];

    AST_PRED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_valid ##1 $stable(pred_pc)) |-> $stable(pred_taken)); // R9

endmodule

// File: tb/tb_cbp_predictor.sv
`timescale 1ns/1ps
module tb_cbp_predictor;

    localparam real HALF = 2.5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    logic [1:0] model [64];
    logic [1:0] mhist;

    always #(HALF) clk = ~clk;

    cbp_predictor dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_pc    (pred_pc),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_pc     (upd_pc),
        .upd_taken  (upd_taken)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: pred_taken=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive, check prediction against pre-update model, then train model.
    task automatic step(input logic [31:0] ppc, input logic uv,
                        input logic [31:0] upc, input logic ut, input string req);
        logic [5:0] ui;
        logic       exp;
        @(negedge clk);
        pred_pc   = ppc;
        upd_valid = uv;
        upd_pc    = upc;
        upd_taken = ut;
        #1;
        exp = model[{ppc[5:2], mhist}][1];
        check(req, pred_taken, exp);
        @(posedge clk);
        if (uv) begin
            ui = {upc[5:2], mhist};
            if (ut && model[ui] != 2'd3) model[ui] = model[ui] + 2'd1;
            else if (!ut && model[ui] != 2'd0) model[ui] = model[ui] - 2'd1;
            mhist = {mhist[0], ut};
        end
    endtask

    initial begin
        #(200000 * 2 * HALF);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 2'b01;
        mhist = 2'b00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every row predicts not-taken out of reset
        for (int r = 0; r < 16; r++) step(32'(r) << 2, 1'b0, '0, 1'b0, "R1");

        // R4 / R3 / R8: train row 5 taken, predicting the same branch each cycle
        for (int k = 0; k < 6; k++) step(32'h14, 1'b1, 32'h14, 1'b1, "R4");
        step(32'h14, 1'b0, '0, 1'b0, "R3");

        // R5: drain row 5 to zero and beyond
        for (int k = 0; k < 7; k++) step(32'h14, 1'b1, 32'h14, 1'b0, "R5");
        step(32'h14, 1'b0, '0, 1'b0, "R5");

        // R2: train row 9 taken, then probe aliases differing only outside PC[5:2]
        for (int k = 0; k < 5; k++) step(32'h24, 1'b1, 32'h24, 1'b1, "R2");
        step(32'hFFFF_FFE4, 1'b0, '0, 1'b0, "R2");
        step(32'h0000_0027, 1'b0, '0, 1'b0, "R2");
        step(32'h1234_5664, 1'b0, '0, 1'b0, "R2");
        step(32'h0000_0028, 1'b0, '0, 1'b0, "R2");
        // update through an alias must hit the same counter
        for (int k = 0; k < 4; k++) step(32'h24, 1'b1, 32'hABCD_0026, 1'b0, "R2");

        // R6 / R7: alternating outcomes on row 7; history picks distinct counters
        for (int k = 0; k < 12; k++) step(32'h1C, 1'b1, 32'h1C, k[0], "R6");
        for (int k = 0; k < 8; k++) step(32'h1C, 1'b1, 32'h1C, k[1], "R7");
        for (int h = 0; h < 4; h++) begin
            step(32'h1C, 1'b1, 32'h00, h[1], "R7");
            step(32'h1C, 1'b1, 32'h00, h[0], "R6");
            step(32'h1C, 1'b0, '0, 1'b0, "R6");
        end

        // R9: update fields toggle with valid low; predictions must not move
        for (int k = 0; k < 32; k++)
            step(32'(k % 16) << 2, 1'b0, 32'(k * 7) << 2, k[0], "R9");

        // R8: random concurrent predict and update, frequently on one row
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] a = $urandom;
            logic [31:0] b = ($urandom % 3 == 0) ? a : $urandom;
            step(a, ($urandom % 4) != 0, b, $urandom % 2, "R8");
        end

        // full sweep of every counter visible after the random run
        for (int r = 0; r < 16; r++) step(32'(r) << 2, 1'b0, '0, 1'b0, "R3");

        // R1: reset again mid-run clears trained state
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 64; i++) model[i] = 2'b01;
        mhist = 2'b00;
        for (int r = 0; r < 16; r++) step(32'(r) << 2, 1'b0, '0, 1'b0, "R1");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule